// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Sequencer

This block turns single bus-cycle requests from an 8-bit core into T-state-accurate pin activity on a bus with a 16-bit address. The low address byte and the data byte share one set of pins. The sequencer accepts one of five cycle kinds: opcode fetch, memory read, memory write, port read and port write. It then steps through the T-states of that kind, one T-state per clock. It drives the upper address byte, the shared byte lane with its output enable, an address-latch strobe, active-low read and write strobes, a memory/port select and a two-bit status code. At the end of a cycle it returns a one-cycle completion pulse, along with the byte captured on a read.

A slow target holds the ready input low to stretch the strobe phase with wait states. An external master can ask for the bus with the hold input. The request is granted only between cycles. The block then raises the acknowledge output and drops the enables of every bus output it drives, so the pads can float.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset the block is idle: `rd_n_o` and `wr_n_o` are 1; `ale_o`, `ad_oe_o`, `hlda_o`, `done_o`, `iom_o`, `s1_o` and `s0_o` are 0; `bus_oe_o` is 1; `rd_data_o` is 0.
- R2: The request kind is encoded as 0 = opcode fetch, 1 = memory read, 2 = memory write, 3 = port read and 4 = port write. A request with kind 0 to 4 is taken in an idle cycle while `hold_in` is low: `req_ack_o` is high in that cycle and T1 follows in the next cycle. Kinds 5 to 7 are ignored: there is no acknowledge and the bus stays idle.
- R3: `ale_o` is high in T1 only. During T1, `ad_o` carries the low address byte with `ad_oe_o` high, and `addr_hi_o` carries the upper address byte for memory cycles.
- R4: For port cycles, the 8-bit port number (`req_addr[7:0]`) appears on both `addr_hi_o` and `ad_o` in T1. `iom_o` is high from T1 to the last T-state of port cycles only.
- R5: `{s1_o,s0_o}` is 2'b11 for an opcode fetch, 2'b10 for a read and 2'b01 for a write, from T1 through the last T-state. The code is 2'b00 in idle and hold.
- R6: For fetch and read kinds, `rd_n_o` is low in T2, in every wait state and in T3, and `ad_oe_o` is low throughout. `ad_i` is sampled at the clock edge that ends T3 and appears on `rd_data_o`, where it stays until the next read.
- R7: For write kinds, `wr_n_o` is low in T2, in every wait state and in T3, with `ad_o` carrying the write byte and `ad_oe_o` high.
- R8: With `rdy_in` high, memory and port cycles last 3 T-states and an opcode fetch lasts 4 T-states (6 with `req_long`). `done_o` pulses for one cycle, in the cycle after the last T-state.
- R9: If `rdy_in` is low at the end of T2 or of a wait state, another wait state follows. T3 follows the first of those edges at which `rdy_in` is high.
- R10: `hold_in` is sampled only at the end of an idle cycle, a hold cycle or the last T-state. When it is high, the next cycle is a hold cycle: `hlda_o` is 1, `bus_oe_o`, `ad_oe_o` and `ale_o` are 0, and no request is taken. `hlda_o` drops in the cycle after `hold_in` is seen low.
- R11: When a valid request and `hold_in` are both present in the same idle cycle, the hold wins: there is no acknowledge, and the bus is handed over in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one T-state per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cycle request present |
| req_kind | input | 3 | Cycle kind code |
| req_long | input | 1 | Selects the 6 T-state opcode fetch |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 8 | Byte to write |
| req_ack_o | output | 1 | Request taken this cycle |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 8 | Last byte read |
| rdy_in | input | 1 | Target ready; low inserts wait states |
| hold_in | input | 1 | External master asks for the bus |
| hlda_o | output | 1 | Bus handed over |
| addr_hi_o | output | 8 | Upper address lines |
| ad_o | output | 8 | Shared lane, outgoing value |
| ad_oe_o | output | 1 | Drive enable for the shared lane |
| ad_i | input | 8 | Shared lane, incoming value |
| ale_o | output | 1 | Address latch strobe |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| iom_o | output | 1 | High for port cycles |
| s1_o | output | 1 | Status bit 1 |
| s0_o | output | 1 | Status bit 0 |
| bus_oe_o | output | 1 | Drive enable for address, strobes and status |

## Verification
Two things can land on the same clock: a hold request and a new cycle request. They can meet in an idle cycle, or the hold request can rise during a cycle and become due at its last T-state, just as the caller prepares the next request. The bench raises hold while a read is in progress, raises it together with a request in an idle cycle, and keeps a request pending through a whole hold period. It also holds ready low across a window that straddles T2. A behavioural model compares every output on every cycle. The model grants the bus before any request and expects no acknowledge, and no strobe or drive enable, until the hold is gone.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  // T-states of the sequencer
  typedef enum logic [3:0] {
    ST_TI, ST_T1, ST_T2, ST_TW, ST_T3, ST_T4, ST_T5, ST_T6, ST_TH
  } tstate_e;

  // Cycle kinds as presented on req_kind
  typedef enum logic [2:0] {
    CY_FETCH = 3'd0,
    CY_MRD   = 3'd1,
    CY_MWR   = 3'd2,
    CY_IORD  = 3'd3,
    CY_IOWR  = 3'd4
  } cyc_e;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= 3'd4;
  endfunction

  function automatic logic kind_reads(input cyc_e k);
    return (k == CY_FETCH) || (k == CY_MRD) || (k == CY_IORD);
  endfunction

  function automatic logic kind_writes(input cyc_e k);
    return (k == CY_MWR) || (k == CY_IOWR);
  endfunction

  function automatic logic kind_port(input cyc_e k);
    return (k == CY_IORD) || (k == CY_IOWR);
  endfunction

  // Two-bit status: fetch 11, read 10, write 01
  function automatic logic [1:0] status_of(input cyc_e k);
    if (k == CY_FETCH) return 2'b11;
    if (kind_writes(k)) return 2'b01;
    return 2'b10;
  endfunction

  // Final T-state of a cycle kind
  function automatic tstate_e final_state(input cyc_e k, input logic lng);
    if (k == CY_FETCH) return lng ? ST_T6 : ST_T4;
    return ST_T3;
  endfunction

  function automatic logic in_cycle(input tstate_e s);
    return (s != ST_TI) && (s != ST_TH);
  endfunction

  function automatic logic strobe_phase(input tstate_e s);
    return (s == ST_T2) || (s == ST_TW) || (s == ST_T3);
  endfunction

endpackage

// File: rtl/bus_seq_fsm.sv
module bus_seq_fsm
  import bus_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  cyc_e       kind_q,
  input  logic       long_q,
  input  logic       rdy_in,
  input  logic       hold_in,
  output tstate_e    state,
  output logic       take,
  output logic       ev_last,
  output logic       ev_wait
);

  tstate_e state_q, state_d, after_last;

  assign state   = state_q;
  assign take    = (state_q == ST_TI) && !hold_in && req_valid && kind_ok(req_kind);
  assign ev_last = in_cycle(state_q) && (state_q == final_state(kind_q, long_q));
  assign ev_wait = (state_q == ST_TW);

  // At the end of a cycle, the bus may be handed over at once
  assign after_last = hold_in ? ST_TH : ST_TI;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_TI:        state_d = hold_in ? ST_TH : (take ? ST_T1 : ST_TI);
      ST_T1:        state_d = ST_T2;
      ST_T2, ST_TW: state_d = rdy_in ? ST_T3 : ST_TW;
      ST_T3:        state_d = ev_last ? after_last : ST_T4;
      ST_T4:        state_d = ev_last ? after_last : ST_T5;
      ST_T5:        state_d = ST_T6;
      ST_T6:        state_d = after_last;
      ST_TH:        state_d = hold_in ? ST_TH : ST_TI;
      default:      state_d = ST_TI;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_TI;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/bus_seq_reqreg.sv
module bus_seq_reqreg
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [2:0]    req_kind,
  input  logic          req_long,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output cyc_e          kind_q,
  output logic          long_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= CY_FETCH;
      long_q  <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      kind_q  <= cyc_e'(req_kind);
      long_q  <= req_long;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

endmodule

// File: rtl/bus_seq_pins.sv
module bus_seq_pins
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  tstate_e          state,
  input  cyc_e             kind_q,
  input  logic [AW-1:0]    addr_q,
  input  logic [DW-1:0]    wdata_q,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             iom_o,
  output logic [1:0]       status_o,
  output logic             bus_oe_o,
  output logic             hlda_o
);

  localparam int AHW = AW - DW;

  logic             busy;
  logic             strb;
  logic [AHW-1:0]   port_hi;
  logic [AHW-1:0]   mem_hi;

  assign busy    = in_cycle(state);
  assign strb    = strobe_phase(state);
  assign port_hi = AHW'(addr_q[DW-1:0]);
  assign mem_hi  = addr_q[AW-1:DW];

  assign addr_hi_o = busy ? (kind_port(kind_q) ? port_hi : mem_hi) : '0;
  assign ale_o     = (state == ST_T1);
  assign ad_o      = ale_o ? addr_q[DW-1:0] : wdata_q;
  assign ad_oe_o   = ale_o || (strb && kind_writes(kind_q));
  assign rd_n_o    = !(strb && kind_reads(kind_q));
  assign wr_n_o    = !(strb && kind_writes(kind_q));
  assign iom_o     = busy && kind_port(kind_q);
  assign status_o  = busy ? status_of(kind_q) : 2'b00;
  assign hlda_o    = (state == ST_TH);
  assign bus_oe_o  = !hlda_o;

endmodule

// File: rtl/bus_seq_rdcap.sv
module bus_seq_rdcap
  import bus_seq_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tstate_e       state,
  input  cyc_e          kind_q,
  input  logic          ev_last,
  input  logic [DW-1:0] ad_i,
  output logic [DW-1:0] rd_data_o,
  output logic          done_o
);

  logic grab;
  assign grab = (state == ST_T3) && kind_reads(kind_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= ev_last;
      if (grab) rd_data_o <= ad_i;
    end
  end

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import bus_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_kind,
  input  logic             req_long,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             req_ack_o,
  output logic             done_o,
  output logic [DW-1:0]    rd_data_o,
  input  logic             rdy_in,
  input  logic             hold_in,
  output logic             hlda_o,
  output logic [AW-DW-1:0] addr_hi_o,
  output logic [DW-1:0]    ad_o,
  output logic             ad_oe_o,
  input  logic [DW-1:0]    ad_i,
  output logic             ale_o,
  output logic             rd_n_o,
  output logic             wr_n_o,
  output logic             iom_o,
  output logic             s1_o,
  output logic             s0_o,
  output logic             bus_oe_o
);

  tstate_e       state;
  cyc_e          kind_q;
  logic          long_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [1:0]    status;

  // Named internal events, used by the checker
  logic take;
  logic ev_last;
  logic ev_wait;

  bus_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .kind_q    (kind_q),
    .long_q    (long_q),
    .rdy_in    (rdy_in),
    .hold_in   (hold_in),
    .state     (state),
    .take      (take),
    .ev_last   (ev_last),
    .ev_wait   (ev_wait)
  );

  bus_seq_reqreg #(.AW(AW), .DW(DW)) u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .req_kind  (req_kind),
    .req_long  (req_long),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .kind_q    (kind_q),
    .long_q    (long_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q)
  );

  bus_seq_pins #(.AW(AW), .DW(DW)) u_pins (
    .state     (state),
    .kind_q    (kind_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .addr_hi_o (addr_hi_o),
    .ad_o      (ad_o),
    .ad_oe_o   (ad_oe_o),
    .ale_o     (ale_o),
    .rd_n_o    (rd_n_o),
    .wr_n_o    (wr_n_o),
    .iom_o     (iom_o),
    .status_o  (status),
    .bus_oe_o  (bus_oe_o),
    .hlda_o    (hlda_o)
  );

  bus_seq_rdcap #(.DW(DW)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .kind_q    (kind_q),
    .ev_last   (ev_last),
    .ad_i      (ad_i),
    .rd_data_o (rd_data_o),
    .done_o    (done_o)
  );

  assign req_ack_o = take;
  assign s1_o      = status[1];
  assign s0_o      = status[0];

endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_in,
  input logic hold_in,
  input logic req_ack_o,
  input logic ale_o,
  input logic ad_oe_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic iom_o,
  input logic s1_o,
  input logic s0_o,
  input logic bus_oe_o,
  input logic hlda_o,
  input logic done_o,
  input logic ev_last,
  input logic ev_wait
);

  a_r2_ack_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack_o |=> ale_o);

  a_r3_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> !ale_o);

  a_r3_ale_drives_lane: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |-> (ad_oe_o && rd_n_o && wr_n_o));

  a_r4_port_is_rw: assert property (@(posedge clk) disable iff (!rst_n)
    iom_o |-> (s1_o != s0_o));

  a_r5_status_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ale_o |=> $stable({s1_o, s0_o, iom_o}));

  a_r6_read_lane_free: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !ad_oe_o);

  a_r7_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n_o && !wr_n_o));

  a_r8_done_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    ev_last |=> done_o);

  a_r9_wait_needs_low_ready: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wait |-> $past(!rdy_in));

  a_r10_hold_floats: assert property (@(posedge clk) disable iff (!rst_n)
    hlda_o |-> (!bus_oe_o && !ad_oe_o && !ale_o && rd_n_o && wr_n_o));

  a_r10_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda_o && !hold_in) |=> !hlda_o);

  a_r11_hold_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hold_in |-> !req_ack_o);

endmodule

bind mux_bus_seq mux_bus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rdy_in    (rdy_in),
  .hold_in   (hold_in),
  .req_ack_o (req_ack_o),
  .ale_o     (ale_o),
  .ad_oe_o   (ad_oe_o),
  .rd_n_o    (rd_n_o),
  .wr_n_o    (wr_n_o),
  .iom_o     (iom_o),
  .s1_o      (s1_o),
  .s0_o      (s0_o),
  .bus_oe_o  (bus_oe_o),
  .hlda_o    (hlda_o),
  .done_o    (done_o),
  .ev_last   (ev_last),
  .ev_wait   (ev_wait)
);

// File: tb/mux_bus_seq_bench.sv
`timescale 1ns/1ps
module mux_bus_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'd0;
  logic        req_long = 1'b0;
  logic [15:0] req_addr = 16'h0;
  logic [7:0]  req_wdata = 8'h0;
  logic        rdy_in = 1'b1;
  logic        hold_in = 1'b0;
  logic [7:0]  ad_i = 8'h5a;
  logic        req_ack_o, done_o, hlda_o, ad_oe_o, ale_o;
  logic        rd_n_o, wr_n_o, iom_o, s1_o, s0_o, bus_oe_o;
  logic [7:0]  rd_data_o, addr_hi_o, ad_o;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  mux_bus_seq u_mux_bus_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_long(req_long), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ack_o(req_ack_o), .done_o(done_o), .rd_data_o(rd_data_o),
    .rdy_in(rdy_in), .hold_in(hold_in), .hlda_o(hlda_o),
    .addr_hi_o(addr_hi_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ad_i(ad_i),
    .ale_o(ale_o), .rd_n_o(rd_n_o), .wr_n_o(wr_n_o), .iom_o(iom_o),
    .s1_o(s1_o), .s0_o(s0_o), .bus_oe_o(bus_oe_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  // position: 0 idle, 1..6 T-state number (waits stay at 2), 9 hold
  localparam int HOLDP = 9;
  int          m_pos = 0;
  int          m_kind = 0;
  bit          m_long = 1'b0;
  logic [15:0] m_addr = 16'h0;
  logic [7:0]  m_wd = 8'h0;
  logic [7:0]  m_rd = 8'h0;
  bit          m_done = 1'b0;

  function automatic int mlen();
    if (m_kind == 0) return m_long ? 6 : 4;
    return 3;
  endfunction
  function automatic bit mrd();
    return (m_kind == 0) || (m_kind == 1) || (m_kind == 3);
  endfunction
  function automatic bit mwr();
    return (m_kind == 2) || (m_kind == 4);
  endfunction
  function automatic bit mio();
    return (m_kind == 3) || (m_kind == 4);
  endfunction
  function automatic bit exp_ack();
    return (m_pos == 0) && !hold_in && req_valid && (req_kind <= 3'd4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos <= 0; m_kind <= 0; m_long <= 1'b0; m_addr <= 16'h0;
      m_wd <= 8'h0; m_rd <= 8'h0; m_done <= 1'b0;
    end else begin
      m_done <= (m_pos >= 1) && (m_pos <= 6) && (m_pos == mlen());
      if (m_pos == 3 && mrd()) m_rd <= ad_i;
      if (m_pos == 0) begin
        if (hold_in) m_pos <= HOLDP;
        else if (exp_ack()) begin
          m_pos <= 1; m_kind <= int'(req_kind); m_long <= req_long;
          m_addr <= req_addr; m_wd <= req_wdata;
        end
      end else if (m_pos == HOLDP) begin
        m_pos <= hold_in ? HOLDP : 0;
      end else if (m_pos == mlen()) begin
        m_pos <= hold_in ? HOLDP : 0;
      end else if (m_pos == 2) begin
        m_pos <= rdy_in ? 3 : 2;
      end else begin
        m_pos <= m_pos + 1;
      end
    end
  end

  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) ad_i <= ad_i * 8'd13 + 8'd7;

  int n_ack = 0;
  int n_done = 0;

  // Per-cycle comparison, away from both edges
  always @(negedge clk) begin
    #1;
    begin
      bit inc, strb, e_adoe;
      logic [1:0] e_st;
      logic [7:0] e_hi, e_ad;
      inc  = (m_pos >= 1) && (m_pos <= 6);
      strb = (m_pos == 2) || (m_pos == 3);
      e_adoe = (m_pos == 1) || (mwr() && strb);
      e_st = !inc ? 2'b00 : (m_kind == 0) ? 2'b11 : mwr() ? 2'b01 : 2'b10;
      e_hi = !inc ? 8'h00 : mio() ? m_addr[7:0] : m_addr[15:8];
      e_ad = (m_pos == 1) ? m_addr[7:0] : m_wd;
      if (req_ack_o) n_ack++;
      if (done_o) n_done++;
      chk(req_ack_o == exp_ack(), "R2/R11 req_ack_o", req_ack_o, exp_ack());
      chk(ale_o == (m_pos == 1), "R3 ale_o", ale_o, m_pos == 1);
      chk(ad_oe_o == e_adoe, "R6/R7 ad_oe_o", ad_oe_o, e_adoe);
      if (e_adoe) chk(ad_o == e_ad, "R3/R7 ad_o", ad_o, e_ad);
      if (m_pos != HOLDP) chk(addr_hi_o == e_hi, "R3/R4 addr_hi_o", addr_hi_o, e_hi);
      chk(rd_n_o == !(mrd() && strb), "R6/R9 rd_n_o", rd_n_o, !(mrd() && strb));
      chk(wr_n_o == !(mwr() && strb), "R7/R9 wr_n_o", wr_n_o, !(mwr() && strb));
      chk(iom_o == (inc && mio()), "R4 iom_o", iom_o, inc && mio());
      chk({s1_o, s0_o} == e_st, "R5 status", {s1_o, s0_o}, e_st);
      chk(hlda_o == (m_pos == HOLDP), "R10 hlda_o", hlda_o, m_pos == HOLDP);
      chk(bus_oe_o == (m_pos != HOLDP), "R10 bus_oe_o", bus_oe_o, m_pos != HOLDP);
      chk(done_o == m_done, "R8 done_o", done_o, m_done);
      chk(rd_data_o == m_rd, "R6 rd_data_o", rd_data_o, m_rd);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wait_ack(output int at);
    #2;
    while (!req_ack_o) begin @(negedge clk); #2; end
    at = cyc;
  endtask

  task automatic wait_done(output int at);
    while (!done_o) begin @(negedge clk); #2; end
    at = cyc;
  endtask

  task automatic run_cycle(input logic [2:0] k, input logic [15:0] a,
                           input logic [7:0] w, input logic lng,
                           input int exp_len, input string tag);
    int t0, t1;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a; req_wdata = w; req_long = lng;
    wait_ack(t0);
    @(negedge clk);
    req_valid = 1'b0;
    #2;
    wait_done(t1);
    chk((t1 - t0) == exp_len + 1, tag, t1 - t0, exp_len + 1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int ta, td, base;
    repeat (3) @(negedge clk);
    #2;
    // R1: reset state
    chk(rd_n_o && wr_n_o && !ale_o && !ad_oe_o, "R1 strobes idle", {rd_n_o, wr_n_o, ale_o, ad_oe_o}, 4'b1100);
    chk(!hlda_o && bus_oe_o && !done_o, "R1 hold/done idle", {hlda_o, bus_oe_o, done_o}, 3'b010);
    chk(rd_data_o == 8'h00, "R1 rd_data_o", rd_data_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: lengths of every kind, R3-R7 checked cycle by cycle
    run_cycle(3'd1, 16'h1234, 8'h00, 1'b0, 3, "R8 memory read length");
    run_cycle(3'd2, 16'hbeef, 8'ha5, 1'b0, 3, "R8 memory write length");
    run_cycle(3'd3, 16'h7f42, 8'h00, 1'b0, 3, "R8 port read length");
    run_cycle(3'd4, 16'h0c99, 8'h3c, 1'b0, 3, "R8 port write length");
    run_cycle(3'd0, 16'h8001, 8'h00, 1'b0, 4, "R8 fetch length");
    run_cycle(3'd0, 16'hfffe, 8'h00, 1'b1, 6, "R8 long fetch length");

    // R2: invalid kinds are ignored
    base = n_ack;
    for (int k = 5; k < 8; k++) begin
      @(negedge clk);
      req_valid = 1'b1; req_kind = 3'(k); req_addr = 16'h4444;
      repeat (3) @(negedge clk);
      #2;
      chk(n_ack == base && !ale_o, "R2 invalid kind ignored", n_ack - base, 0);
    end
    @(negedge clk); req_valid = 1'b0;

    // R9: ready low across T2 gives three wait states
    @(negedge clk);
    rdy_in = 1'b0;
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h2468;
    wait_ack(ta);
    @(negedge clk); req_valid = 1'b0;
    repeat (4) @(negedge clk);
    rdy_in = 1'b1;
    #2;
    wait_done(td);
    chk((td - ta) == 7, "R9 wait stretch", td - ta, 7);
    // R9: write with one wait state
    @(negedge clk);
    rdy_in = 1'b0;
    req_valid = 1'b1; req_kind = 3'd4; req_addr = 16'h0011; req_wdata = 8'h96;
    wait_ack(ta);
    @(negedge clk); req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rdy_in = 1'b1;
    #2;
    wait_done(td);
    chk((td - ta) == 5, "R9 write wait stretch", td - ta, 5);

    // R10: hold raised during a read is granted at its end
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd3; req_addr = 16'h0055;
    wait_ack(ta);
    @(negedge clk); req_valid = 1'b0; hold_in = 1'b1;
    #2;
    wait_done(td);
    chk(hlda_o && !bus_oe_o, "R10 hold granted with done", {hlda_o, bus_oe_o}, 2'b10);
    base = n_ack;
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd2; req_addr = 16'h9999; req_wdata = 8'h11;
    repeat (4) @(negedge clk);
    #2;
    chk(n_ack == base && hlda_o, "R10 no request while held", n_ack - base, 0);
    @(negedge clk); hold_in = 1'b0;
    @(negedge clk); #2;
    chk(!hlda_o && req_ack_o, "R10 release then take", {hlda_o, req_ack_o}, 2'b01);
    @(negedge clk); req_valid = 1'b0;
    #2;
    wait_done(td);

    // R11: hold and request in the same idle cycle
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd1; req_addr = 16'h3210; hold_in = 1'b1;
    #2;
    chk(!req_ack_o, "R11 hold beats request", req_ack_o, 0);
    @(negedge clk); #2;
    chk(hlda_o, "R11 bus handed over", hlda_o, 1);
    repeat (2) @(negedge clk);
    hold_in = 1'b0;
    wait_ack(ta);
    @(negedge clk); req_valid = 1'b0;
    #2;
    wait_done(td);
    chk((td - ta) == 4, "R11 delayed request completes", td - ta, 4);

    // R8: one done per taken request
    repeat (3) @(negedge clk);
    #2;
    chk(n_ack == n_done, "R8 done per request", n_done, n_ack);
    summary();
  end

endmodule